// File: doc/BRIEF.md
# Port Bandwidth Calendar Encoder

This block turns a per-port speed selection into the configuration of a switch's automatic bandwidth calendar. A start pulse clears its state. Speed codes for up to seventy ports then arrive one port per accepted cycle, in port order. Each code is packed into a 3-bit field of a set of configuration words, and the bandwidth it stands for is added to two running sums. One sum covers the front ports only. The other is the total that the switch core must carry.

When the last port has arrived, both sums are compared against their limits. The front-port sum is checked against a target supplied on an input. The total is checked against a ceiling taken from the selected core clock. If both checks pass, the block runs a fixed update sequence on a simple masked register-write bus, then reads back the control register to look for an error flag. A single done pulse reports the outcome on separate pass and fail flags.

Top module: `portcal_encoder`

## Requirements
- R1: Speed codes are 1 = 1000, 2 = 2500, 3 = 5000, 4 = 10000, 5 = 25000, 6 = 500 and 7 = 12500 Mb/s. A port with code 0 adds no bits and no bandwidth.
- R2: Port p lands in word p/10 at bits [3*(p%10)+2 : 3*(p%10)]. Unused bits are zero. All words are cleared by start.
- R3: If the front-port sum (ports 0..64) is above `target_bw_i`, the run ends with fail and no bus writes. A sum equal to the target passes this check.
- R4: Ports 65..69 add half of their value to the total and nothing to the front-port sum.
- R5: The core ceiling is 83000 for `clk_sel_i`=0, 166000 for 1 and 208000 for 2. A total above the ceiling ends with fail and no bus writes. A total equal to the ceiling passes.
- R6: A start with `clk_sel_i`=3 gives done with fail on the next cycle. No writes are made and no ports are taken.
- R7: A passing check makes ten consecutive writes, in this order:
  - address 0, mask 0x000F, data 10 (halt mode in bits [3:0]);
  - word k at address 1+k, mask all ones, for k = 0..6;
  - address 0, mask 0x3FF0, data 671<<4 (grant rate in bits [13:4]);
  - address 0, mask 0x000F, data 8 (auto mode).
- R8: In the cycle after the last write, `rd_en_o` reads address 0 for one cycle. The data returned on the following cycle is sampled. Bit 16 set gives fail, and clear gives pass.
- R9: `done_o` is a one-cycle pulse carrying exactly one of `pass_o` and `fail_o`. Both flags are low whenever done is low.
- R10: Ports are taken only in cycles with `port_vld_i` high, numbered in order of arrival. Gaps are allowed. A start while a run is busy is ignored.
- R11: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (taken when idle) |
| clk_sel_i | input | 2 | Core clock select, 0/1/2 valid |
| target_bw_i | input | 22 | Front-port bandwidth target in Mb/s |
| port_vld_i | input | 1 | A port speed code is offered |
| port_code_i | input | 3 | Speed code of the next port |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 4 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_mask_o | output | 32 | Bits of the register that the write changes |
| rd_en_o | output | 1 | Register read strobe |
| rd_addr_o | output | 4 | Read address |
| rd_data_i | input | 32 | Read data, one cycle after the strobe |
| done_o | output | 1 | Run finished (one-cycle pulse) |
| pass_o | output | 1 | Run succeeded, valid with done |
| fail_o | output | 1 | Run failed, valid with done |

## Verification
The bench drives both limits to exact equality and to one step beyond. A comparison written as greater-or-equal would fail the equal cases, and a missing comparison would let the over-limit cases write. It loads only the upper ports with large codes, so a design that counted them in full, or counted them toward the front target, would fail a run that should pass. It also covers an invalid clock select, which a faulty design would either hang on or answer by writing the bus. Further runs cover a set error bit on readback, gaps in the port stream, and a second start in the middle of a run. Every run compares each written word and control field with a model built from the requirements.

// File: rtl/portcal_pkg.sv
package portcal_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      SPD_NONE = 3'd0,
      SPD_1G   = 3'd1,
      SPD_2G5  = 3'd2,
      SPD_5G   = 3'd3,
      SPD_10G  = 3'd4,
      SPD_25G  = 3'd5,
      SPD_0G5  = 3'd6,
      SPD_12G5 = 3'd7
   } spd_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACCUM,
      ST_CHECK,
      ST_WRITE,
      ST_READ,
      ST_SAMPLE
   } seq_state_e;

   // Bandwidth in Mb/s for each speed code
   function automatic int unsigned spd_mbps(input logic [CODE_W-1:0] code);
      case (spd_code_e'(code))
         SPD_1G:   return 1000;
         SPD_2G5:  return 2500;
         SPD_5G:   return 5000;
         SPD_10G:  return 10000;
         SPD_25G:  return 25000;
         SPD_0G5:  return 500;
         SPD_12G5: return 12500;
         default:  return 0;
      endcase
   endfunction

   // Core throughput ceiling: one third of the selected core clock in MHz
   function automatic int unsigned core_ceiling(input logic [1:0] sel);
      case (sel)
         2'd0:    return 83000;
         2'd1:    return 166000;
         2'd2:    return 208000;
         default: return 0;
      endcase
   endfunction

   function automatic logic clk_sel_ok(input logic [1:0] sel);
      return sel != 2'd3;
   endfunction

endpackage

// File: rtl/portcal_packer.sv
module portcal_packer
   import portcal_pkg::*;
#(
   parameter int NUM_WORDS      = 7,
   parameter int PORTS_PER_WORD = 10,
   parameter int DATA_W         = 32,
   parameter int WIDX_W         = 3,
   parameter int SIDX_W         = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr_i,
   input  logic                             vld_i,
   input  logic [CODE_W-1:0]                code_i,
   input  logic [WIDX_W-1:0]                word_idx_i,
   input  logic [SIDX_W-1:0]                slot_idx_i,
   output logic [NUM_WORDS-1:0][DATA_W-1:0] words_o
);

   logic [$clog2(DATA_W+1)-1:0] bit_off;
   assign bit_off = $bits(bit_off)'(int'(slot_idx_i) * CODE_W);

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words_o[g] <= '0;
         end else if (clr_i) begin
            words_o[g] <= '0;
         end else if (vld_i && (code_i != SPD_NONE) && (word_idx_i == WIDX_W'(g))) begin
            words_o[g][bit_off +: CODE_W] <= code_i;
         end
      end
   end

endmodule

// File: rtl/portcal_accum.sv
module portcal_accum
   import portcal_pkg::*;
#(
   parameter int FRONT_PORTS = 65,
   parameter int BW_W        = 22,
   parameter int IDX_W       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              vld_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [IDX_W-1:0]  port_idx_i,
   output logic [BW_W-1:0]   front_sum_o,
   output logic [BW_W-1:0]   total_sum_o
);

   logic [BW_W-1:0] bw;
   logic            is_front;

   assign bw       = BW_W'(spd_mbps(code_i));
   assign is_front = int'(port_idx_i) < FRONT_PORTS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         front_sum_o <= '0;
         total_sum_o <= '0;
      end else if (clr_i) begin
         front_sum_o <= '0;
         total_sum_o <= '0;
      end else if (vld_i) begin
         if (is_front) begin
            front_sum_o <= front_sum_o + bw;
            total_sum_o <= total_sum_o + bw;
         end else begin
            total_sum_o <= total_sum_o + (bw >> 1);
         end
      end
   end

endmodule

// File: rtl/portcal_seq.sv
module portcal_seq
   import portcal_pkg::*;
#(
   parameter int NUM_PORTS      = 70,
   parameter int NUM_WORDS      = 7,
   parameter int PORTS_PER_WORD = 10,
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 4,
   parameter int BW_W           = 22,
   parameter int IDX_W          = 7,
   parameter int WIDX_W         = 3,
   parameter int SIDX_W         = 4,
   parameter int CTRL_ADDR      = 0,
   parameter int WORD_BASE      = 1,
   parameter int MODE_LSB       = 0,
   parameter int MODE_W         = 4,
   parameter int GRANT_LSB      = 4,
   parameter int GRANT_W        = 10,
   parameter int HALT_MODE      = 10,
   parameter int AUTO_MODE      = 8,
   parameter int GRANT_RATE     = 671
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start_i,
   input  logic [1:0]                       clk_sel_i,
   input  logic [BW_W-1:0]                  target_bw_i,
   input  logic                             port_vld_i,
   input  logic [BW_W-1:0]                  front_sum_i,
   input  logic [BW_W-1:0]                  total_sum_i,
   input  logic [NUM_WORDS-1:0][DATA_W-1:0] words_i,
   input  logic                             status_err_i,
   output logic                             acc_clr_o,
   output logic                             acc_vld_o,
   output logic [IDX_W-1:0]                 port_idx_o,
   output logic [WIDX_W-1:0]                word_idx_o,
   output logic [SIDX_W-1:0]                slot_idx_o,
   output logic                             wr_en_o,
   output logic [ADDR_W-1:0]                wr_addr_o,
   output logic [DATA_W-1:0]                wr_data_o,
   output logic [DATA_W-1:0]                wr_mask_o,
   output logic                             rd_en_o,
   output logic [ADDR_W-1:0]                rd_addr_o,
   output logic                             done_o,
   output logic                             pass_o,
   output logic                             fail_o
);

   localparam int STEPS  = NUM_WORDS + 3;
   localparam int STEP_W = $clog2(STEPS + 1);

   seq_state_e        state_q;
   logic [STEP_W-1:0] step_q;
   logic [1:0]        sel_q;
   logic [BW_W-1:0]   target_q;
   logic              over_limit;
   logic [WIDX_W-1:0] word_sel;

   assign acc_clr_o  = (state_q == ST_IDLE) && start_i;
   assign acc_vld_o  = (state_q == ST_ACCUM) && port_vld_i;
   assign over_limit = (front_sum_i > target_q) ||
                       (total_sum_i > BW_W'(core_ceiling(sel_q)));
   assign word_sel   = WIDX_W'(int'(step_q) - 1);
   assign rd_en_o    = (state_q == ST_READ);
   assign rd_addr_o  = ADDR_W'(CTRL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         step_q     <= '0;
         sel_q      <= '0;
         target_q   <= '0;
         port_idx_o <= '0;
         word_idx_o <= '0;
         slot_idx_o <= '0;
         done_o     <= 1'b0;
         pass_o     <= 1'b0;
         fail_o     <= 1'b0;
      end else begin
         done_o <= 1'b0;
         pass_o <= 1'b0;
         fail_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  port_idx_o <= '0;
                  word_idx_o <= '0;
                  slot_idx_o <= '0;
                  sel_q      <= clk_sel_i;
                  target_q   <= target_bw_i;
                  if (!clk_sel_ok(clk_sel_i)) begin
                     done_o <= 1'b1;
                     fail_o <= 1'b1;
                  end else begin
                     state_q <= ST_ACCUM;
                  end
               end
            end
            ST_ACCUM: begin
               if (port_vld_i) begin
                  port_idx_o <= port_idx_o + 1'b1;
                  if (int'(slot_idx_o) == PORTS_PER_WORD - 1) begin
                     slot_idx_o <= '0;
                     word_idx_o <= word_idx_o + 1'b1;
                  end else begin
                     slot_idx_o <= slot_idx_o + 1'b1;
                  end
                  if (int'(port_idx_o) == NUM_PORTS - 1) state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               step_q <= '0;
               if (over_limit) begin
                  done_o  <= 1'b1;
                  fail_o  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               step_q <= step_q + 1'b1;
               if (int'(step_q) == STEPS - 1) state_q <= ST_READ;
            end
            ST_READ: state_q <= ST_SAMPLE;
            ST_SAMPLE: begin
               done_o  <= 1'b1;
               pass_o  <= !status_err_i;
               fail_o  <= status_err_i;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Write bus decoded from the step counter
   always_comb begin
      wr_en_o   = (state_q == ST_WRITE);
      wr_addr_o = ADDR_W'(CTRL_ADDR);
      wr_data_o = '0;
      wr_mask_o = '0;
      if (state_q == ST_WRITE) begin
         if (step_q == '0) begin
            wr_data_o[MODE_LSB +: MODE_W] = MODE_W'(HALT_MODE);
            wr_mask_o[MODE_LSB +: MODE_W] = '1;
         end else if (int'(step_q) <= NUM_WORDS) begin
            wr_addr_o = ADDR_W'(WORD_BASE + int'(word_sel));
            wr_data_o = words_i[word_sel];
            wr_mask_o = '1;
         end else if (int'(step_q) == NUM_WORDS + 1) begin
            wr_data_o[GRANT_LSB +: GRANT_W] = GRANT_W'(GRANT_RATE);
            wr_mask_o[GRANT_LSB +: GRANT_W] = '1;
         end else begin
            wr_data_o[MODE_LSB +: MODE_W] = MODE_W'(AUTO_MODE);
            wr_mask_o[MODE_LSB +: MODE_W] = '1;
         end
      end
   end

endmodule

// File: rtl/portcal_encoder.sv
module portcal_encoder
   import portcal_pkg::*;
#(
   parameter int NUM_PORTS      = 70,
   parameter int FRONT_PORTS    = 65,
   parameter int PORTS_PER_WORD = 10,
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 4,
   parameter int BW_W           = 22,
   parameter int CTRL_ADDR      = 0,
   parameter int WORD_BASE      = 1,
   parameter int MODE_LSB       = 0,
   parameter int MODE_W         = 4,
   parameter int GRANT_LSB      = 4,
   parameter int GRANT_W        = 10,
   parameter int ERR_BIT        = 16,
   parameter int HALT_MODE      = 10,
   parameter int AUTO_MODE      = 8,
   parameter int GRANT_RATE     = 671
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [1:0]          clk_sel_i,
   input  logic [BW_W-1:0]     target_bw_i,
   input  logic                port_vld_i,
   input  logic [2:0]          port_code_i,
   output logic                wr_en_o,
   output logic [ADDR_W-1:0]   wr_addr_o,
   output logic [DATA_W-1:0]   wr_data_o,
   output logic [DATA_W-1:0]   wr_mask_o,
   output logic                rd_en_o,
   output logic [ADDR_W-1:0]   rd_addr_o,
   input  logic [DATA_W-1:0]   rd_data_i,
   output logic                done_o,
   output logic                pass_o,
   output logic                fail_o
);

   localparam int NUM_WORDS = (NUM_PORTS + PORTS_PER_WORD - 1) / PORTS_PER_WORD;
   localparam int IDX_W     = $clog2(NUM_PORTS + 1);
   localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int SIDX_W    = (PORTS_PER_WORD > 1) ? $clog2(PORTS_PER_WORD) : 1;

   // Elaboration-time parameter checks
   if (PORTS_PER_WORD * CODE_W > DATA_W) begin : g_bad_pack
      $error("port fields do not fit in one data word");
   end
   if (FRONT_PORTS > NUM_PORTS) begin : g_bad_front
      $error("front-port count exceeds port count");
   end
   if (WORD_BASE + NUM_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("configuration words exceed the address space");
   end
   if ((GRANT_LSB + GRANT_W > DATA_W) || (MODE_LSB + MODE_W > DATA_W) || (ERR_BIT >= DATA_W)) begin : g_bad_field
      $error("control field outside the data word");
   end
   if (BW_W < 18) begin : g_bad_bw
      $error("bandwidth width too small for the core ceiling");
   end

   logic                             acc_clr, acc_vld;
   logic [IDX_W-1:0]                 port_idx;
   logic [WIDX_W-1:0]                word_idx;
   logic [SIDX_W-1:0]                slot_idx;
   logic [BW_W-1:0]                  front_sum, total_sum;
   logic [NUM_WORDS-1:0][DATA_W-1:0] words;
   logic                             unused_rd;

   assign unused_rd = ^rd_data_i;

   portcal_packer #(
      .NUM_WORDS(NUM_WORDS), .PORTS_PER_WORD(PORTS_PER_WORD), .DATA_W(DATA_W),
      .WIDX_W(WIDX_W), .SIDX_W(SIDX_W)
   ) packer_i (
      .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .vld_i(acc_vld),
      .code_i(port_code_i), .word_idx_i(word_idx), .slot_idx_i(slot_idx),
      .words_o(words)
   );

   portcal_accum #(
      .FRONT_PORTS(FRONT_PORTS), .BW_W(BW_W), .IDX_W(IDX_W)
   ) accum_i (
      .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .vld_i(acc_vld),
      .code_i(port_code_i), .port_idx_i(port_idx),
      .front_sum_o(front_sum), .total_sum_o(total_sum)
   );

   portcal_seq #(
      .NUM_PORTS(NUM_PORTS), .NUM_WORDS(NUM_WORDS), .PORTS_PER_WORD(PORTS_PER_WORD),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BW_W(BW_W), .IDX_W(IDX_W),
      .WIDX_W(WIDX_W), .SIDX_W(SIDX_W), .CTRL_ADDR(CTRL_ADDR), .WORD_BASE(WORD_BASE),
      .MODE_LSB(MODE_LSB), .MODE_W(MODE_W), .GRANT_LSB(GRANT_LSB), .GRANT_W(GRANT_W),
      .HALT_MODE(HALT_MODE), .AUTO_MODE(AUTO_MODE), .GRANT_RATE(GRANT_RATE)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_sel_i(clk_sel_i),
      .target_bw_i(target_bw_i), .port_vld_i(port_vld_i),
      .front_sum_i(front_sum), .total_sum_i(total_sum), .words_i(words),
      .status_err_i(rd_data_i[ERR_BIT]),
      .acc_clr_o(acc_clr), .acc_vld_o(acc_vld), .port_idx_o(port_idx),
      .word_idx_o(word_idx), .slot_idx_o(slot_idx),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .wr_mask_o(wr_mask_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
      .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
   );

endmodule

// File: rtl/portcal_encoder_chk.sv
module portcal_encoder_chk #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 0,
   parameter int MODE_LSB  = 0,
   parameter int MODE_W    = 4,
   parameter int HALT_MODE = 10,
   parameter int AUTO_MODE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic [DATA_W-1:0] wr_mask_o,
   input logic              rd_en_o,
   input logic              done_o,
   input logic              pass_o,
   input logic              fail_o
);

   AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_o && rd_en_o)); // R8

   AST_FLAG_ONE_OF: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o != fail_o)); // R9

   AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (!pass_o && !fail_o)); // R9

   AST_HALT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en_o) |-> (wr_addr_o == ADDR_W'(CTRL_ADDR)) &&
                         (wr_data_o[MODE_LSB +: MODE_W] == MODE_W'(HALT_MODE)) &&
                         (wr_mask_o[MODE_LSB +: MODE_W] == '1)); // R7

   AST_AUTO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_en_o) |-> rd_en_o &&
                         $past(wr_data_o[MODE_LSB +: MODE_W] == MODE_W'(AUTO_MODE))); // R7

   AST_PASS_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> $past(rd_en_o, 2)); // R8

endmodule

bind portcal_encoder portcal_encoder_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MODE_LSB(MODE_LSB),
   .MODE_W(MODE_W), .HALT_MODE(HALT_MODE), .AUTO_MODE(AUTO_MODE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
   .wr_data_o(wr_data_o), .wr_mask_o(wr_mask_o), .rd_en_o(rd_en_o),
   .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
);

// File: tb/portcal_encoder_tb_top.sv
`timescale 1ns/1ps
module portcal_encoder_tb_top;

   typedef struct packed {
      logic [3:0]  pat;
      logic [1:0]  sel;
      logic [21:0] target;
      logic        err;
      logic        gap;
      logic        restart;
      logic [3:0]  req;
   } tv_t;

   localparam int NTV = 14;
   localparam tv_t TV [NTV] = '{
      '{4'd0, 2'd0, 22'd0,      1'b0, 1'b0, 1'b0, 4'd1},
      '{4'd1, 2'd2, 22'd129000, 1'b0, 1'b0, 1'b0, 4'd2},
      '{4'd1, 2'd0, 22'd200000, 1'b0, 1'b0, 1'b0, 4'd5},
      '{4'd1, 2'd1, 22'd106500, 1'b0, 1'b0, 1'b0, 4'd3},
      '{4'd1, 2'd1, 22'd106499, 1'b0, 1'b0, 1'b0, 4'd3},
      '{4'd2, 2'd2, 22'd201000, 1'b0, 1'b0, 1'b0, 4'd3},
      '{4'd3, 2'd0, 22'd0,      1'b0, 1'b0, 1'b0, 4'd4},
      '{4'd4, 2'd0, 22'd201000, 1'b0, 1'b0, 1'b0, 4'd5},
      '{4'd5, 2'd0, 22'd201000, 1'b0, 1'b0, 1'b0, 4'd5},
      '{4'd1, 2'd2, 22'd129000, 1'b1, 1'b0, 1'b0, 4'd8},
      '{4'd1, 2'd2, 22'd129000, 1'b0, 1'b1, 1'b0, 4'd10},
      '{4'd1, 2'd2, 22'd129000, 1'b0, 1'b0, 1'b1, 4'd10},
      '{4'd0, 2'd3, 22'd0,      1'b0, 1'b0, 1'b0, 4'd6},
      '{4'd6, 2'd0, 22'd65000,  1'b0, 1'b0, 1'b0, 4'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  clk_sel_i = '0;
   logic [21:0] target_bw_i = '0;
   logic        port_vld_i = 1'b0;
   logic [2:0]  port_code_i = '0;
   logic        wr_en_o, rd_en_o, done_o, pass_o, fail_o;
   logic [3:0]  wr_addr_o, rd_addr_o;
   logic [31:0] wr_data_o, wr_mask_o;
   logic [31:0] rd_data_i = '0;
   logic        cur_err = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [3:0]  lg_addr [256];
   logic [31:0] lg_data [256];
   logic [31:0] lg_mask [256];
   int wr_n = 0;
   int rd_n = 0;

   always #2 clk = ~clk;

   portcal_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_sel_i(clk_sel_i),
      .target_bw_i(target_bw_i), .port_vld_i(port_vld_i), .port_code_i(port_code_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .wr_mask_o(wr_mask_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
      .rd_data_i(rd_data_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
   );

   // Register-file stand-in: one-cycle read latency, error flag at bit 16
   always @(posedge clk) begin
      rd_data_i <= (rd_en_o && rd_addr_o == 4'd0) ? (32'(cur_err) << 16) : 32'd0;
   end

   // Bus monitor
   always @(negedge clk) begin
      if (wr_en_o) begin
         if (wr_n < 256) begin
            lg_addr[wr_n] <= wr_addr_o;
            lg_data[wr_n] <= wr_data_o;
            lg_mask[wr_n] <= wr_mask_o;
         end
         wr_n <= wr_n + 1;
      end
      if (rd_en_o) rd_n <= rd_n + 1;
   end

   function automatic string req_name(input int r);
      case (r)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         8: return "R8";
         10: return "R10";
         default: return "R9";
      endcase
   endfunction

   function automatic logic [2:0] code_of(input int pat, input int p);
      case (pat)
         1: return (p % 5 == 0) ? 3'(p % 8) : 3'd0;
         2: return 3'd4;
         3: return (p >= 65) ? 3'd5 : 3'd0;
         4: return (p < 3) ? 3'd5 : ((p < 11) ? 3'd1 : 3'd0);
         5: return (p < 3) ? 3'd5 : ((p < 11) ? 3'd1 : ((p == 11) ? 3'd6 : 3'd0));
         6: return 3'd6;
         default: return 3'd0;
      endcase
   endfunction

   function automatic int mbps(input logic [2:0] c);
      case (c)
         3'd1: return 1000;  3'd2: return 2500;  3'd3: return 5000;
         3'd4: return 10000; 3'd5: return 25000; 3'd6: return 500;
         3'd7: return 12500; default: return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_case(input int i);
      tv_t t = TV[i];
      logic [31:0] ew [7];
      int front = 0;
      int total = 0;
      int ceil_v;
      bit sel_ok, lim_ok, exp_pass;
      int wr0, rd0, n;
      string rq = req_name(int'(t.req));
      for (int k = 0; k < 7; k++) ew[k] = '0;
      for (int p = 0; p < 70; p++) begin
         logic [2:0] c = code_of(int'(t.pat), p);
         ew[p / 10] |= 32'(c) << (3 * (p % 10));
         if (p < 65) begin front += mbps(c); total += mbps(c); end
         else total += mbps(c) / 2;
      end
      ceil_v   = (t.sel == 2'd0) ? 83000 : (t.sel == 2'd1) ? 166000 : 208000;
      sel_ok   = (t.sel != 2'd3);
      lim_ok   = sel_ok && (front <= int'(t.target)) && (total <= ceil_v);
      exp_pass = lim_ok && !t.err;

      wr0 = wr_n; rd0 = rd_n;
      @(negedge clk);
      clk_sel_i = t.sel; target_bw_i = t.target; cur_err = t.err;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (sel_ok) begin
         for (int p = 0; p < 70; p++) begin
            if (t.gap && (p % 2 == 1)) begin
               port_vld_i = 1'b0;
               @(negedge clk);
            end
            port_vld_i = 1'b1;
            port_code_i = code_of(int'(t.pat), p);
            if (t.restart && p == 30) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
         end
         port_vld_i = 1'b0;
         port_code_i = '0;
      end
      n = 0;
      while (!done_o && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(done_o == 1'b1, rq, $sformatf("case %0d done seen", i), done_o, 1);
      chk(pass_o == exp_pass, rq, $sformatf("case %0d pass", i), pass_o, exp_pass);
      chk(fail_o == !exp_pass, rq, $sformatf("case %0d fail", i), fail_o, !exp_pass);
      chk((wr_n - wr0) == (lim_ok ? 10 : 0), rq, $sformatf("case %0d write count", i),
          wr_n - wr0, lim_ok ? 10 : 0);
      chk((rd_n - rd0) == (lim_ok ? 1 : 0), "R8", $sformatf("case %0d read count", i),
          rd_n - rd0, lim_ok ? 1 : 0);
      if (lim_ok && (wr_n - wr0) == 10) begin
         chk(lg_addr[wr0] == 4'd0 && lg_data[wr0] == 32'd10 && lg_mask[wr0] == 32'h0000000F,
             "R7", $sformatf("case %0d halt write", i), lg_data[wr0], 10);
         for (int k = 0; k < 7; k++) begin
            chk(lg_addr[wr0+1+k] == 4'(1 + k) && lg_mask[wr0+1+k] == 32'hFFFFFFFF &&
                lg_data[wr0+1+k] == ew[k], "R2",
                $sformatf("case %0d word %0d", i, k), lg_data[wr0+1+k], ew[k]);
         end
         chk(lg_addr[wr0+8] == 4'd0 && lg_data[wr0+8] == (32'd671 << 4) &&
             lg_mask[wr0+8] == 32'h00003FF0, "R7", $sformatf("case %0d grant write", i),
             lg_data[wr0+8], 32'd671 << 4);
         chk(lg_addr[wr0+9] == 4'd0 && lg_data[wr0+9] == 32'd8 && lg_mask[wr0+9] == 32'h0000000F,
             "R7", $sformatf("case %0d auto write", i), lg_data[wr0+9], 8);
      end
      @(negedge clk);
      chk(!done_o && !pass_o && !fail_o, "R9", $sformatf("case %0d done is a pulse", i),
          {done_o, pass_o, fail_o}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!wr_en_o && !rd_en_o && !done_o && !pass_o && !fail_o, "R11", "outputs in reset",
          {wr_en_o, rd_en_o, done_o, pass_o, fail_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!wr_en_o && !rd_en_o && !done_o && !pass_o && !fail_o, "R11", "outputs after reset",
          {wr_en_o, rd_en_o, done_o, pass_o, fail_o}, 0);
      for (int i = 0; i < NTV; i++) run_case(i);
      // Corner: offered ports while idle are not taken (R10)
      port_vld_i = 1'b1; port_code_i = 3'd7;
      repeat (5) @(negedge clk);
      port_vld_i = 1'b0;
      chk(!wr_en_o && !done_o, "R10", "idle ignores ports", {wr_en_o, done_o}, 0);
      run_case(0);
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule